// File: doc/BRIEF.md
# Four-Mode Operand Address Former

This block turns one operand reference into a logical address: a segment selector plus a displacement inside that segment. The displacement is the sum of a base part and an index part. The index part is scaled by the operand size. The selector, the base and the index each carry a flag. When the flag is clear, the field holds the value itself. When the flag is set, the field holds a pointer, and the value is read from memory.

The two displacement flags give four access modes. Both parts literal addresses a scalar. A pointer base with a literal index addresses a record field. A literal base with a pointer index addresses an element of a static array. Both parts through pointers addresses an element of a dynamic array. All four modes are accepted for every request, and an indirect selector can be combined with any of them.

Reads go out one at a time over a level request / acknowledge port. The fetch order is fixed: selector first, then base, then index. A part given directly skips its read. When the address is complete, it is presented with a one-cycle done strobe, and the block is idle again in that same cycle.

Top module: `opnd_addr_gen`

## Requirements
- R1: While reset is asserted and directly after it, `req_ready` is 1, `done` is 0 and `rd_req` is 0.
- R2: A request is accepted only in a cycle where `req_ready` is 1. While a request is in progress, `req_valid` and the field inputs have no effect on the result, and only one `done` is produced for the accepted request.
- R3: Indirect parts are fetched in the order selector, base, index. Each read address equals the low `ADDR_W` bits of that part's field.
- R4: A part whose flag is 0 issues no read. A request with all three flags 0 raises `done` in the second cycle after the accepting clock edge, and no read is issued for it.
- R5: Only one read is outstanding at a time. `rd_req` stays high with a stable `rd_addr` until a cycle in which `rd_ack` is high.
- R6: The size code shifts the index left by the code's value for codes 0 to 4, which gives ×1, ×2, ×4, ×8 and ×16. Codes 5 to 7 shift by 4.
- R7: `disp_out` equals the base plus the shifted index, truncated to `DISP_W` bits.
- R8: A value fetched for a part is the low bits of `rd_data`, taken in the cycle `rd_ack` is high. For a literal part, the value is the low bits of the field.
- R9: `done` is high for exactly one cycle per accepted request. `sel_out` and `disp_out` are valid while `done` is high.
- R10: All four displacement modes (scalar, record, static array, dynamic array) work with the selector given either directly or indirectly.
- R11: `req_ready` is 1 in the cycle `done` is high, so a new request can be accepted in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe, sampled only when idle |
| req_ready | output | 1 | Block is idle and will accept a request |
| sel_ind | input | 1 | Selector field is a pointer |
| sel_fld | input | FLD_W | Selector value or pointer |
| base_ind | input | 1 | Base field is a pointer |
| base_fld | input | FLD_W | Base value or pointer |
| idx_ind | input | 1 | Index field is a pointer |
| idx_fld | input | FLD_W | Index value or pointer |
| size_code | input | 3 | Operand size code (0 = byte ... 4 = extended word) |
| rd_req | output | 1 | Read request, held until acknowledged |
| rd_addr | output | ADDR_W | Read address |
| rd_ack | input | 1 | Read acknowledge, qualifies rd_data |
| rd_data | input | DATA_W | Read data |
| done | output | 1 | One-cycle completion strobe |
| sel_out | output | SEL_W | Resulting segment selector |
| disp_out | output | DISP_W | Resulting displacement |

## Verification
The completion of one request and the acceptance of the next can fall in the same cycle, because the block returns to idle as it raises `done`. The bench provokes this by driving a new all-literal request on the very cycle `done` is seen. It then checks that the first result is intact, that the second request completes two cycles later with its own values, and that `done` never holds for two cycles in a row. Separately, `req_valid` is held high with different fields across a whole fetch sequence. That run must return only the first request's address, once.

// File: rtl/oag_pkg.sv
package oag_pkg;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_SEL  = 3'd1,
      ST_BASE = 3'd2,
      ST_IDX  = 3'd3,
      ST_ADD  = 3'd4
   } oag_state_e;

   // Stage codes used to pick the next fetch: 0 idle, 1 selector, 2 base, 3 index
   function automatic oag_state_e oag_next(input logic [1:0] after,
                                           input logic s_ind,
                                           input logic b_ind,
                                           input logic i_ind);
      oag_state_e nxt;
      nxt = ST_ADD;
      if (after == 2'd0 && s_ind)
         nxt = ST_SEL;
      else if (after <= 2'd1 && b_ind)
         nxt = ST_BASE;
      else if (after <= 2'd2 && i_ind)
         nxt = ST_IDX;
      return nxt;
   endfunction

   // Size code to shift amount; codes above 4 saturate at 4
   function automatic logic [2:0] oag_shift(input logic [2:0] code);
      return (code > 3'd4) ? 3'd4 : code;
   endfunction

endpackage

// File: rtl/oag_scale.sv
module oag_scale #(
   parameter int IDX_W  = 16,
   parameter int DISP_W = 16,
   parameter bit USE_MUX = 1'b0
) (
   input  logic [IDX_W-1:0]  idx,
   input  logic [2:0]        shamt,
   output logic [DISP_W-1:0] scaled
);
   localparam int XW = (DISP_W > IDX_W + 4) ? DISP_W : IDX_W + 4;

   logic [XW-1:0] ext;
   assign ext = XW'(idx);

   generate
      if (USE_MUX) begin : g_mux
         logic [XW-1:0] cand [5];
         for (genvar k = 0; k < 5; k++) begin : g_cand
            assign cand[k] = ext << k;
         end
         logic [XW-1:0] pick;
         always_comb begin
            pick = cand[4];
            for (int k = 0; k < 4; k++)
               if (shamt == 3'(k)) pick = cand[k];
         end
         assign scaled = pick[DISP_W-1:0];
      end else begin : g_shift
         logic [XW-1:0] sh;
         assign sh     = ext << shamt;
         assign scaled = sh[DISP_W-1:0];
      end
   endgenerate

endmodule

// File: rtl/oag_seq.sv
module oag_seq
   import oag_pkg::*;
#(
   parameter int FLD_W  = 16,
   parameter int ADDR_W = 16,
   parameter int DATA_W = 16,
   parameter int SEL_W  = 12,
   parameter int DISP_W = 16,
   parameter int IDX_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              sel_ind,
   input  logic [FLD_W-1:0]  sel_fld,
   input  logic              base_ind,
   input  logic [FLD_W-1:0]  base_fld,
   input  logic              idx_ind,
   input  logic [FLD_W-1:0]  idx_fld,
   input  logic [2:0]        size_code,
   output logic              rd_req,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic              rd_ack,
   input  logic [DATA_W-1:0] rd_data,
   output logic [SEL_W-1:0]  sel_v,
   output logic [DISP_W-1:0] base_v,
   output logic [IDX_W-1:0]  idx_v,
   output logic [2:0]        shamt,
   output logic              fire
);
   oag_state_e       state_q;
   logic [FLD_W-1:0] sel_r, base_r, idx_r;
   logic [2:0]       sz_r;
   logic             s_ind_r, b_ind_r, i_ind_r;
   logic [FLD_W-1:0] fetched;

   assign fetched   = FLD_W'(rd_data);
   assign req_ready = (state_q == ST_IDLE);
   assign rd_req    = (state_q == ST_SEL) || (state_q == ST_BASE) || (state_q == ST_IDX);
   assign fire      = (state_q == ST_ADD);

   always_comb begin
      case (state_q)
         ST_SEL:  rd_addr = sel_r[ADDR_W-1:0];
         ST_BASE: rd_addr = base_r[ADDR_W-1:0];
         ST_IDX:  rd_addr = idx_r[ADDR_W-1:0];
         default: rd_addr = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         sel_r   <= '0;
         base_r  <= '0;
         idx_r   <= '0;
         sz_r    <= '0;
         s_ind_r <= 1'b0;
         b_ind_r <= 1'b0;
         i_ind_r <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: if (req_valid) begin
               sel_r   <= sel_fld;
               base_r  <= base_fld;
               idx_r   <= idx_fld;
               sz_r    <= size_code;
               s_ind_r <= sel_ind;
               b_ind_r <= base_ind;
               i_ind_r <= idx_ind;
               state_q <= oag_next(2'd0, sel_ind, base_ind, idx_ind);
            end
            ST_SEL: if (rd_ack) begin
               sel_r   <= fetched;
               state_q <= oag_next(2'd1, s_ind_r, b_ind_r, i_ind_r);
            end
            ST_BASE: if (rd_ack) begin
               base_r  <= fetched;
               state_q <= oag_next(2'd2, s_ind_r, b_ind_r, i_ind_r);
            end
            ST_IDX: if (rd_ack) begin
               idx_r   <= fetched;
               state_q <= ST_ADD;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign sel_v  = sel_r[SEL_W-1:0];
   assign base_v = base_r[DISP_W-1:0];
   assign idx_v  = idx_r[IDX_W-1:0];
   assign shamt  = oag_shift(sz_r);

endmodule

// File: rtl/opnd_addr_gen.sv
module opnd_addr_gen #(
   parameter int FLD_W   = 16,
   parameter int ADDR_W  = 16,
   parameter int DATA_W  = 16,
   parameter int SEL_W   = 12,
   parameter int DISP_W  = 16,
   parameter int IDX_W   = 16,
   parameter bit USE_MUX = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              sel_ind,
   input  logic [FLD_W-1:0]  sel_fld,
   input  logic              base_ind,
   input  logic [FLD_W-1:0]  base_fld,
   input  logic              idx_ind,
   input  logic [FLD_W-1:0]  idx_fld,
   input  logic [2:0]        size_code,
   output logic              rd_req,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic              rd_ack,
   input  logic [DATA_W-1:0] rd_data,
   output logic              done,
   output logic [SEL_W-1:0]  sel_out,
   output logic [DISP_W-1:0] disp_out
);
   generate
      if (FLD_W < ADDR_W) begin : g_bad_fld_addr
         $error("FLD_W must hold a pointer of ADDR_W bits");
      end
      if (FLD_W < SEL_W || FLD_W < DISP_W || FLD_W < IDX_W) begin : g_bad_fld_val
         $error("FLD_W must hold each literal part");
      end
      if (DATA_W < SEL_W || DATA_W < DISP_W || DATA_W < IDX_W) begin : g_bad_data
         $error("DATA_W must hold each fetched part");
      end
   endgenerate

   logic [SEL_W-1:0]  sel_v;
   logic [DISP_W-1:0] base_v;
   logic [IDX_W-1:0]  idx_v;
   logic [2:0]        shamt;
   logic              fire;
   logic [DISP_W-1:0] scaled;

   oag_seq #(
      .FLD_W(FLD_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .SEL_W(SEL_W), .DISP_W(DISP_W), .IDX_W(IDX_W)
   ) u_seq (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready),
      .sel_ind(sel_ind), .sel_fld(sel_fld),
      .base_ind(base_ind), .base_fld(base_fld),
      .idx_ind(idx_ind), .idx_fld(idx_fld),
      .size_code(size_code),
      .rd_req(rd_req), .rd_addr(rd_addr),
      .rd_ack(rd_ack), .rd_data(rd_data),
      .sel_v(sel_v), .base_v(base_v), .idx_v(idx_v),
      .shamt(shamt), .fire(fire)
   );

   oag_scale #(
      .IDX_W(IDX_W), .DISP_W(DISP_W), .USE_MUX(USE_MUX)
   ) u_scale (
      .idx(idx_v), .shamt(shamt), .scaled(scaled)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done     <= 1'b0;
         sel_out  <= '0;
         disp_out <= '0;
      end else begin
         done <= fire;
         if (fire) begin
            sel_out  <= sel_v;
            disp_out <= base_v + scaled;
         end
      end
   end

endmodule

// File: rtl/oag_chk.sv
module oag_chk #(
   parameter int ADDR_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              sel_ind,
   input logic              base_ind,
   input logic              idx_ind,
   input logic              rd_req,
   input logic [ADDR_W-1:0] rd_addr,
   input logic              rd_ack,
   input logic              done
);
   a_r5_req_held: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr)));

   a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r2_idle_no_read: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !rd_req);

   a_r4_direct_latency: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && !sel_ind && !base_ind && !idx_ind)
      |=> (!rd_req && !done) ##1 done);

   a_r11_done_ready: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> req_ready);

endmodule

bind opnd_addr_gen oag_chk #(.ADDR_W(ADDR_W)) i_chk (
   .clk(clk), .rst_n(rst_n),
   .req_valid(req_valid), .req_ready(req_ready),
   .sel_ind(sel_ind), .base_ind(base_ind), .idx_ind(idx_ind),
   .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack),
   .done(done)
);

// File: tb/test_opnd_addr_gen.sv
`timescale 1ns/1ps
module test_opnd_addr_gen;
   localparam int FW = 16, AW = 16, DW = 16, SW = 12, PW = 16, IW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic          sel_ind = 1'b0, base_ind = 1'b0, idx_ind = 1'b0;
   logic [FW-1:0] sel_fld = '0, base_fld = '0, idx_fld = '0;
   logic [2:0]    size_code = '0;
   logic          rd_req;
   logic [AW-1:0] rd_addr;
   logic          rd_ack = 1'b0;
   logic [DW-1:0] rd_data = '0;
   logic          done;
   logic [SW-1:0] sel_out;
   logic [PW-1:0] disp_out;

   int checks = 0, fails = 0;
   int cycles = 0;
   bit finished = 0;
   logic [AW-1:0] log_a [8];
   int log_n = 0;
   int wait_cnt = 0;

   always #5 clk = ~clk;

   opnd_addr_gen i_opnd_addr_gen (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready),
      .sel_ind(sel_ind), .sel_fld(sel_fld),
      .base_ind(base_ind), .base_fld(base_fld),
      .idx_ind(idx_ind), .idx_fld(idx_fld),
      .size_code(size_code),
      .rd_req(rd_req), .rd_addr(rd_addr),
      .rd_ack(rd_ack), .rd_data(rd_data),
      .done(done), .sel_out(sel_out), .disp_out(disp_out)
   );

   function automatic logic [DW-1:0] memf(input logic [AW-1:0] a);
      return (a * 16'h9E37) ^ 16'h5A5A;
   endfunction

   function automatic logic [PW-1:0] exp_disp(input logic bi, input logic [FW-1:0] bf,
                                              input logic ii, input logic [FW-1:0] xf,
                                              input logic [2:0] sz);
      logic [31:0] b, x;
      int sh;
      b  = bi ? 32'(memf(bf[AW-1:0])) : 32'(bf[PW-1:0]);
      x  = ii ? 32'(memf(xf[AW-1:0])) : 32'(xf[IW-1:0]);
      sh = (sz > 3'd4) ? 4 : int'(sz);
      return PW'(b + (x << sh));
   endfunction

   function automatic logic [SW-1:0] exp_sel(input logic si, input logic [FW-1:0] sf);
      return si ? memf(sf[AW-1:0])[SW-1:0] : sf[SW-1:0];
   endfunction

   task automatic check(input bit ok, input string req, input longint act, input longint expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   // memory model: acknowledges after 0..3 idle cycles, logs granted addresses
   initial begin
      forever begin
         @(negedge clk);
         if (rd_req && !rd_ack) begin
            if (wait_cnt == 0) begin
               rd_ack  = 1'b1;
               rd_data = memf(rd_addr);
               if (log_n < 8) log_a[log_n] = rd_addr;
               log_n++;
               wait_cnt = $urandom % 4;
            end else begin
               wait_cnt--;
            end
         end else begin
            rd_ack = 1'b0;
         end
      end
   end

   // watchdog
   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 150000 && !finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
         end
      end
   end

   task automatic drive(input logic si, input logic [FW-1:0] sf, input logic bi,
                        input logic [FW-1:0] bf, input logic ii, input logic [FW-1:0] xf,
                        input logic [2:0] sz);
      sel_ind = si; sel_fld = sf; base_ind = bi; base_fld = bf;
      idx_ind = ii; idx_fld = xf; size_code = sz; req_valid = 1'b1;
   endtask

   task automatic check_reads(input logic si, input logic [FW-1:0] sf, input logic bi,
                              input logic [FW-1:0] bf, input logic ii, input logic [FW-1:0] xf);
      logic [AW-1:0] ex [3];
      int n = 0;
      if (si) begin ex[n] = sf[AW-1:0]; n++; end
      if (bi) begin ex[n] = bf[AW-1:0]; n++; end
      if (ii) begin ex[n] = xf[AW-1:0]; n++; end
      check(log_n == n, "R4 read count", log_n, n);
      for (int k = 0; k < n && k < log_n; k++)
         check(log_a[k] == ex[k], "R3 read order/address", log_a[k], ex[k]);
   endtask

   task automatic do_op(input logic si, input logic [FW-1:0] sf, input logic bi,
                        input logic [FW-1:0] bf, input logic ii, input logic [FW-1:0] xf,
                        input logic [2:0] sz);
      int cyc = 0;
      while (!req_ready) @(negedge clk);
      log_n = 0;
      drive(si, sf, bi, bf, ii, xf, sz);
      @(negedge clk);
      req_valid = 1'b0;
      cyc = 1;
      while (!done && cyc < 60) begin
         @(negedge clk);
         cyc++;
      end
      check(done == 1'b1, "R9 done seen", done, 1);
      if (!si && !bi && !ii) check(cyc == 2, "R4 direct latency", cyc, 2);
      check(sel_out == exp_sel(si, sf), "R8 selector", sel_out, exp_sel(si, sf));
      check(disp_out == exp_disp(bi, bf, ii, xf, sz), "R7 R10 displacement",
            disp_out, exp_disp(bi, bf, ii, xf, sz));
      check(req_ready == 1'b1, "R11 ready with done", req_ready, 1);
      check_reads(si, sf, bi, bf, ii, xf);
      @(negedge clk);
      check(done == 1'b0, "R9 done one cycle", done, 0);
   endtask

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      check(req_ready == 1'b1 && done == 1'b0 && rd_req == 1'b0, "R1 in reset",
            {req_ready, done, rd_req}, 3'b100);
      rst_n = 1'b1;
      @(negedge clk);
      check(req_ready == 1'b1 && done == 1'b0 && rd_req == 1'b0, "R1 after reset",
            {req_ready, done, rd_req}, 3'b100);

      // R6: every size code, scalar mode
      for (int s = 0; s < 8; s++)
         do_op(1'b0, 16'h0123, 1'b0, 16'h1000, 1'b0, 16'h0011, 3'(s));

      // R10: four modes, each with direct and indirect selector
      for (int m = 0; m < 8; m++)
         do_op(m[2], 16'h0A0A + 16'(m), m[1], 16'h2222, m[0], 16'h0303, 3'd2);

      // R7: wrap of the displacement sum
      do_op(1'b0, 16'h0001, 1'b0, 16'hFFF0, 1'b0, 16'h0FFF, 3'd4);

      // R2: request held high with changing fields while busy
      while (!req_ready) @(negedge clk);
      log_n = 0;
      drive(1'b1, 16'h0042, 1'b1, 16'h0043, 1'b1, 16'h0044, 3'd3);
      @(negedge clk);
      begin
         int guard = 0;
         while (!done && guard < 60) begin
            sel_fld = 16'($urandom); base_fld = 16'($urandom); idx_fld = 16'($urandom);
            sel_ind = 1'b0; base_ind = 1'b0; idx_ind = 1'b0; size_code = 3'd0;
            @(negedge clk);
            guard++;
         end
      end
      req_valid = 1'b0;
      check(sel_out == exp_sel(1'b1, 16'h0042), "R2 busy selector", sel_out, exp_sel(1'b1, 16'h0042));
      check(disp_out == exp_disp(1'b1, 16'h0043, 1'b1, 16'h0044, 3'd3), "R2 busy displacement",
            disp_out, exp_disp(1'b1, 16'h0043, 1'b1, 16'h0044, 3'd3));
      check(log_n == 3, "R5 one read per part", log_n, 3);
      @(negedge clk);
      check(done == 1'b0 && req_ready == 1'b1, "R2 single done", {done, req_ready}, 2'b01);

      // R11: back-to-back, new request driven in the done cycle
      log_n = 0;
      drive(1'b0, 16'h0111, 1'b0, 16'h0200, 1'b0, 16'h0005, 3'd1);
      @(negedge clk);
      req_valid = 1'b0;
      @(negedge clk);
      check(done == 1'b1, "R11 first done", done, 1);
      drive(1'b0, 16'h0777, 1'b0, 16'h0300, 1'b0, 16'h0006, 3'd2);
      @(negedge clk);
      req_valid = 1'b0;
      check(done == 1'b0, "R9 no repeat done", done, 0);
      @(negedge clk);
      check(done == 1'b1 && disp_out == 16'h0318 && sel_out == 12'h777, "R11 second result",
            disp_out, 16'h0318);

      // random mix
      for (int t = 0; t < 300; t++)
         do_op(1'($urandom), 16'($urandom), 1'($urandom), 16'($urandom),
               1'($urandom), 16'($urandom), 3'($urandom));

      finished = 1;
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule